// File: doc/BRIEF.md
# Comparator Trip Override for a PWM Output

This block sits between a digital current-sense comparator bit and one PWM output pin. It brings the comparator result into the clock domain, requires it to settle before it is accepted, and can invert it. A trip is raised while the resulting compare signal is low. The trip can pass through a blanking filter. The blanking window is placed after each PWM counter-zero strobe by a programmable offset and length. The trip can also skip that filter and its register. While a trip is active, the selected action overrides the normal PWM value.

In a resonant converter with synchronous rectification, the comparator is set to inverting mode. The rectifier gate is then forced high only while the sensed current is above the threshold. Once the current has fallen, the gate returns to the normal PWM waveform. The block registers the 10-bit threshold code and passes it to the DAC outside. Trip current = code / 1023 × 82.5 full scale. The DAC and the comparator are not part of the block.

Top module: `cmp_trip_override`

## Requirements
- R1: While rst_n is low, trip_event is 0, threshold_out is 0 and pwm_out equals pwm_in.
- R2: cmp_raw passes through two synchronizer flops. It must then differ from the qualified value at qual_len consecutive clock edges before the qualified value takes it (a qual_len of 0 counts as 1). With the filtered path, trip_event changes 3+qual_len edges after cmp_raw changes.
- R3: A cmp_raw pulse shorter than qual_len cycles never changes trip_event.
- R4: The compare signal is the qualified value XOR cfg_invert, and a trip is active while that signal is 0. With cfg_invert=1 a high cmp_raw trips. With cfg_invert=0 a low cmp_raw trips.
- R5: With cfg_blank_en=1 and the filtered path, an active trip inside the blanking window is suppressed. Outside the window it passes.
- R6: After ctr_zero is sampled high at an edge, the cycles are numbered 0, 1, 2 and so on. Cycles numbered offset through offset+window-1 are blanked. The filtered trip_event shows the blanking one edge later. A window of 0 blanks nothing.
- R7: With cfg_async_path=1, trip_event follows the active trip with no register and no blanking. It changes 2+qual_len edges after cmp_raw changes.
- R8: cfg_action encodes 0 = pass pwm_in, 1 = force pwm_out low, 2 = force pwm_out high. The action applies in the same cycle as trip_event.
- R9: cfg_action = 3 holds pwm_out at the value it had in the cycle before trip_event rose, for as long as the trip lasts.
- R10: pwm_out equals pwm_in in the same cycle in which trip_event falls.
- R11: threshold_out equals cfg_threshold one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | 1 | Unsynchronized comparator result |
| ctr_zero | input | 1 | One-cycle strobe at PWM counter zero |
| pwm_in | input | 1 | Normal PWM value |
| cfg_invert | input | 1 | Invert the qualified comparator value |
| cfg_qual_len | input | QUAL_W (4) | Required stable edges |
| cfg_blank_en | input | 1 | Enable the blanking filter |
| cfg_blank_offset | input | BLANK_W (8) | Cycles from strobe to window start |
| cfg_blank_window | input | BLANK_W (8) | Window length in cycles |
| cfg_async_path | input | 1 | Bypass filter and event register |
| cfg_action | input | 2 | Override action code |
| cfg_threshold | input | THR_W (10) | Threshold code for the DAC |
| threshold_out | output | THR_W (10) | Registered threshold code |
| pwm_out | output | 1 | Final PWM pin value |
| trip_event | output | 1 | Trip active |

## Verification
Every result has a fixed latency, counted from the clock edge after the stimulus is driven. On the filtered path, trip_event moves 3+qual_len edges after cmp_raw changes. On the bypass path it moves 2+qual_len edges after. A blanked cycle is seen in trip_event one edge after the cycle it covers. The threshold code appears one edge after it is driven, and pwm_out follows the action and pwm_in within the same cycle. Each check samples 1 ns after the edge on which the result is due. Where it matters, the check also samples the edge before, so that a result that arrives one cycle early or late is caught.

// File: rtl/cto_pkg.sv
package cto_pkg;
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_HOLD = 2'd3
    } trip_act_e;
endpackage

// File: rtl/cto_qualifier.sv
module cto_qualifier #(
    parameter int QUAL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_i,
    input  logic [QUAL_W-1:0] len_i,
    output logic              sync_o,
    output logic              qual_o
);
    typedef struct packed {
        logic              s1;
        logic              s2;
        logic              qual;
        logic [QUAL_W-1:0] cnt;
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic [QUAL_W-1:0] limit;

    always_comb begin
        limit = (len_i == '0) ? '0 : len_i - 1'b1;
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
        if (st_q.s2 == st_q.qual) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= limit) begin
            st_d.qual = st_q.s2;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
    assign qual_o = st_q.qual;
endmodule

// File: rtl/cto_blanker.sv
module cto_blanker #(
    parameter int BLANK_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               zero_i,
    input  logic [BLANK_W-1:0] offset_i,
    input  logic [BLANK_W-1:0] window_i,
    output logic               blank_o
);
    localparam int POS_W = BLANK_W + 1;

    typedef struct packed {
        logic             armed;
        logic [POS_W-1:0] pos;
    } blank_st_t;

    blank_st_t st_d, st_q;
    logic [POS_W-1:0] win_start, win_end;

    always_comb begin
        win_start = {1'b0, offset_i};
        win_end   = {1'b0, offset_i} + {1'b0, window_i};
        st_d = st_q;
        if (zero_i) begin
            st_d.armed = 1'b1;
            st_d.pos   = '0;
        end else if (st_q.armed && (st_q.pos != '1)) begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign blank_o = st_q.armed && (st_q.pos >= win_start) && (st_q.pos < win_end);
endmodule

// File: rtl/cto_override.sv
module cto_override
    import cto_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trip_i,
    input  logic [1:0] action_i,
    input  logic       pwm_i,
    output logic       pwm_o
);
    typedef struct packed {
        logic last;
    } ovr_st_t;

    ovr_st_t   st_d, st_q;
    trip_act_e act;
    logic      pwm_mux;

    always_comb begin
        act = trip_act_e'(action_i);
        pwm_mux = pwm_i;
        if (trip_i) begin
            case (act)
                ACT_LOW:  pwm_mux = 1'b0;
                ACT_HIGH: pwm_mux = 1'b1;
                ACT_HOLD: pwm_mux = st_q.last;
                default:  pwm_mux = pwm_i;
            endcase
        end
        st_d.last = pwm_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = pwm_mux;
endmodule

// File: rtl/cmp_trip_override.sv
module cmp_trip_override #(
    parameter int QUAL_W  = 4,
    parameter int BLANK_W = 8,
    parameter int THR_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmp_raw,
    input  logic               ctr_zero,
    input  logic               pwm_in,
    input  logic               cfg_invert,
    input  logic [QUAL_W-1:0]  cfg_qual_len,
    input  logic               cfg_blank_en,
    input  logic [BLANK_W-1:0] cfg_blank_offset,
    input  logic [BLANK_W-1:0] cfg_blank_window,
    input  logic               cfg_async_path,
    input  logic [1:0]         cfg_action,
    input  logic [THR_W-1:0]   cfg_threshold,
    output logic [THR_W-1:0]   threshold_out,
    output logic               pwm_out,
    output logic               trip_event
);
    typedef struct packed {
        logic             run;
        logic             evt;
        logic [THR_W-1:0] thr;
    } top_st_t;

    top_st_t st_d, st_q;
    logic sync_s, qual_s, blank_s;
    logic cmp_s, active_s, filt_s;

    cto_qualifier #(.QUAL_W(QUAL_W)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (cmp_raw),
        .len_i  (cfg_qual_len),
        .sync_o (sync_s),
        .qual_o (qual_s)
    );

    cto_blanker #(.BLANK_W(BLANK_W)) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_i   (ctr_zero),
        .offset_i (cfg_blank_offset),
        .window_i (cfg_blank_window),
        .blank_o  (blank_s)
    );

    always_comb begin
        cmp_s    = qual_s ^ cfg_invert;
        active_s = st_q.run && !cmp_s;
        filt_s   = active_s && !(cfg_blank_en && blank_s);
        st_d     = st_q;
        st_d.run = 1'b1;
        st_d.evt = filt_s;
        st_d.thr = cfg_threshold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trip_event    = cfg_async_path ? active_s : st_q.evt;
    assign threshold_out = st_q.thr;

    cto_override u_ovr (
        .clk      (clk),
        .rst_n    (rst_n),
        .trip_i   (trip_event),
        .action_i (cfg_action),
        .pwm_i    (pwm_in),
        .pwm_o    (pwm_out)
    );
endmodule

// File: rtl/cmp_trip_override_chk.sv
module cmp_trip_override_chk #(
    parameter int THR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_s,
    input logic             qual_s,
    input logic             blank_s,
    input logic             cfg_blank_en,
    input logic             cfg_async_path,
    input logic [1:0]       cfg_action,
    input logic [THR_W-1:0] cfg_threshold,
    input logic [THR_W-1:0] threshold_out,
    input logic             pwm_in,
    input logic             pwm_out,
    input logic             trip_event
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !trip_event);

    // R2
    qual_from_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_s != $past(qual_s)) |-> ($past(sync_s) == qual_s));

    // R5
    blank_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_blank_en && blank_s && !cfg_async_path) |=> (cfg_async_path || !trip_event));

    // R8
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_event && cfg_action == 2'd1) |-> !pwm_out);

    // R8
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_event && cfg_action == 2'd2) |-> pwm_out);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_event && $past(trip_event) && cfg_action == 2'd3 && $past(cfg_action) == 2'd3)
        |-> $stable(pwm_out));

    // R10
    release_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trip_event) |-> (pwm_out == pwm_in));

    // R11
    thr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) or 1'b1 |=> (threshold_out == $past(cfg_threshold)));
endmodule

bind cmp_trip_override cmp_trip_override_chk #(.THR_W(THR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sync_s         (sync_s),
    .qual_s         (qual_s),
    .blank_s        (blank_s),
    .cfg_blank_en   (cfg_blank_en),
    .cfg_async_path (cfg_async_path),
    .cfg_action     (cfg_action),
    .cfg_threshold  (cfg_threshold),
    .threshold_out  (threshold_out),
    .pwm_in         (pwm_in),
    .pwm_out        (pwm_out),
    .trip_event     (trip_event)
);

// File: tb/cmp_trip_override_bench.sv
`timescale 1ns/1ps
module cmp_trip_override_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_raw = 1'b0;
    logic       ctr_zero = 1'b0;
    logic       pwm_in = 1'b0;
    logic       cfg_invert = 1'b1;
    logic [3:0] cfg_qual_len = 4'd3;
    logic       cfg_blank_en = 1'b0;
    logic [7:0] cfg_blank_offset = 8'd0;
    logic [7:0] cfg_blank_window = 8'd0;
    logic       cfg_async_path = 1'b0;
    logic [1:0] cfg_action = 2'd2;
    logic [9:0] cfg_threshold = 10'd0;
    logic [9:0] threshold_out;
    logic       pwm_out;
    logic       trip_event;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cmp_trip_override u_cmp_trip_override (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .ctr_zero(ctr_zero),
        .pwm_in(pwm_in), .cfg_invert(cfg_invert), .cfg_qual_len(cfg_qual_len),
        .cfg_blank_en(cfg_blank_en), .cfg_blank_offset(cfg_blank_offset),
        .cfg_blank_window(cfg_blank_window), .cfg_async_path(cfg_async_path),
        .cfg_action(cfg_action), .cfg_threshold(cfg_threshold),
        .threshold_out(threshold_out), .pwm_out(pwm_out), .trip_event(trip_event)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input logic [9:0] act, input logic [9:0] exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic t_reset();
        pwm_in = 1'b1;
        tick(2);
        check(trip_event, 0, "R1", "trip in reset");
        check(pwm_out, 1, "R1", "pwm in reset");
        check(threshold_out, 0, "R1", "threshold in reset");
        pwm_in = 1'b0;
        rst_n = 1'b1;
        tick(3);
        check(trip_event, 0, "R1", "idle after reset");
    endtask

    task automatic t_qualify();
        cmp_raw = 1'b1;
        tick(5);
        check(trip_event, 0, "R2", "one edge before due");
        tick(1);
        check(trip_event, 1, "R2", "trip at 3+len");
        check(pwm_out, 1, "R8", "force high");
        cmp_raw = 1'b0;
        tick(5);
        check(trip_event, 1, "R2", "clear one edge early");
        tick(1);
        check(trip_event, 0, "R2", "clear at 3+len");
        check(pwm_out, 0, "R10", "return to pwm_in");
        cfg_qual_len = 4'd1;
        cmp_raw = 1'b1;
        tick(3);
        check(trip_event, 0, "R2", "len1 early");
        tick(1);
        check(trip_event, 1, "R2", "len1 due");
        cmp_raw = 1'b0;
        tick(6);
        cfg_qual_len = 4'd3;
    endtask

    task automatic t_glitch();
        logic seen = 1'b0;
        cmp_raw = 1'b1;
        tick(2);
        cmp_raw = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tick(1);
            if (trip_event) seen = 1'b1;
        end
        check(seen, 0, "R3", "short pulse filtered");
    endtask

    task automatic t_invert();
        cfg_invert = 1'b0;
        tick(1);
        check(trip_event, 1, "R4", "low raw trips uninverted");
        cmp_raw = 1'b1;
        tick(6);
        check(trip_event, 0, "R4", "high raw idle uninverted");
        cfg_invert = 1'b1;
        tick(1);
        check(trip_event, 1, "R4", "high raw trips inverted");
        cmp_raw = 1'b0;
        tick(6);
        check(trip_event, 0, "R4", "low raw idle inverted");
    endtask

    task automatic strobe();
        ctr_zero = 1'b1;
        tick(1);
        ctr_zero = 1'b0;
    endtask

    task automatic t_blank();
        logic drop = 1'b0;
        cmp_raw = 1'b1;
        tick(6);
        check(trip_event, 1, "R5", "active before blanking");
        cfg_blank_en = 1'b1;
        cfg_blank_offset = 8'd2;
        cfg_blank_window = 8'd3;
        strobe();
        tick(2);
        check(trip_event, 1, "R6", "before window");
        tick(1);
        check(trip_event, 0, "R5", "inside window");
        check(pwm_out, 0, "R5", "pwm not forced in window");
        tick(2);
        check(trip_event, 0, "R6", "window last cycle");
        tick(1);
        check(trip_event, 1, "R6", "after window");
        cfg_blank_offset = 8'd0;
        cfg_blank_window = 8'd0;
        strobe();
        for (int i = 0; i < 6; i++) begin
            tick(1);
            if (!trip_event) drop = 1'b1;
        end
        check(drop, 0, "R6", "zero window blanks nothing");
        cfg_blank_window = 8'd2;
        strobe();
        tick(1);
        check(trip_event, 0, "R6", "offset0 first");
        tick(1);
        check(trip_event, 0, "R6", "offset0 second");
        tick(1);
        check(trip_event, 1, "R6", "offset0 end");
    endtask

    task automatic t_async();
        cfg_blank_window = 8'd4;
        cfg_async_path = 1'b1;
        strobe();
        tick(1);
        check(trip_event, 1, "R7", "bypass ignores blanking");
        cmp_raw = 1'b0;
        tick(4);
        check(trip_event, 1, "R7", "bypass early");
        tick(1);
        check(trip_event, 0, "R7", "bypass at 2+len");
        cfg_async_path = 1'b0;
        cfg_blank_en = 1'b0;
        tick(1);
    endtask

    task automatic t_actions();
        cmp_raw = 1'b1;
        tick(6);
        cfg_action = 2'd0; pwm_in = 1'b1; #1;
        check(pwm_out, 1, "R8", "none passes 1");
        pwm_in = 1'b0; #1;
        check(pwm_out, 0, "R8", "none passes 0");
        cfg_action = 2'd1; pwm_in = 1'b1; #1;
        check(pwm_out, 0, "R8", "force low");
        cfg_action = 2'd2; pwm_in = 1'b0; #1;
        check(pwm_out, 1, "R8", "force high");
        cmp_raw = 1'b0;
        tick(6);
        check(trip_event, 0, "R8", "cleared");
    endtask

    task automatic t_hold();
        cfg_action = 2'd3;
        pwm_in = 1'b1;
        tick(1);
        check(pwm_out, 1, "R9", "pre-trip value");
        cmp_raw = 1'b1;
        tick(6);
        check(trip_event, 1, "R9", "trip for hold");
        pwm_in = 1'b0; #1;
        check(pwm_out, 1, "R9", "held over pwm_in");
        tick(3);
        check(pwm_out, 1, "R9", "still held");
        cmp_raw = 1'b0;
        tick(6);
        check(pwm_out, 0, "R10", "release from hold");
        cfg_action = 2'd2;
    endtask

    task automatic t_threshold();
        cfg_threshold = 10'h2A5; #1;
        check(threshold_out, 10'h000, "R11", "not yet");
        tick(1);
        check(threshold_out, 10'h2A5, "R11", "after edge");
        cfg_threshold = 10'h3FF;
        tick(1);
        check(threshold_out, 10'h3FF, "R11", "full code");
    endtask

    initial begin
        #1;
        t_reset();
        t_qualify();
        t_glitch();
        t_invert();
        t_blank();
        t_async();
        t_actions();
        t_hold();
        t_threshold();
        finish_run();
    end

    initial begin
        #500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end
endmodule